// File: doc/BRIEF.md
# Configurable product-term array for one logic block

This block is the AND plane of one logic block in a small programmable-logic fabric. It receives 22 signals from the global interconnect, forms both polarities of each, and builds 64 general product terms plus four control terms from them. The control terms are two shared output-enable terms, one asynchronous-reset term and one asynchronous-preset term. Which literals feed each term is held in an on-block configuration store. That store is written one term-word at a time through an addressed parallel port, gated by a configuration enable.

The 64 general terms leave the block as 16 clusters of four consecutive terms, ready for a downstream allocator. Each of the eight I/O cells picks one of the two output-enable terms through a per-cell select bit held in the same store. The reset and preset terms are single outputs shared by every flip-flop of the block. All term outputs are purely combinational from the inputs and the stored configuration.

Top module: `pt_array`

## Requirements
- R1: While and after reset, every configuration word holds all ones ("erased"): all 64 general terms, both control terms and all eight `io_oe` bits are 0 for any input, and every I/O cell selects output-enable term 1.
- R2: A term is the AND of its connected literals; in a term word, bit 2*i connects input i true and bit 2*i+1 connects input i complemented (bit set = connected).
- R3: A term whose word has no bit set evaluates to 1 for every input.
- R4: A term that connects both polarities of the same input evaluates to 0 for every input.
- R5: Word address 0..63 holds general term n; 64 and 65 hold output-enable terms 0 and 1; 66 holds the reset term driving `areset_term`; 67 holds the preset term driving `apreset_term`; 68 holds the I/O select word in its low 8 bits.
- R6: Cluster c occupies `logic_terms[4c+3:4c]`, with term 4c+k at bit 4c+k.
- R7: `io_oe[i]` equals output-enable term 1 when select bit i is 1, otherwise output-enable term 0.
- R8: A word is written only on a clock edge where `cfg_en` and `cfg_wr` are both high; otherwise the store and every output that depends on it keep their value.
- R9: A write to an address above 68 changes nothing.
- R10: A written word affects the outputs from the clock edge that samples the write; an input change reaches the outputs in the same cycle with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset, erases the store |
| cfg_en | input | 1 | Configuration enable, writes are refused while low |
| cfg_wr | input | 1 | Write strobe for one configuration word |
| cfg_addr | input | 7 | Word address, 0..68 valid |
| cfg_data | input | 44 | Word to store: literal mask, or select bits in [7:0] at address 68 |
| in_vec | input | 22 | Signals from the global interconnect |
| logic_terms | output | 64 | General terms, 16 clusters of four |
| io_oe | output | 8 | Selected output enable for each I/O cell |
| areset_term | output | 1 | Shared asynchronous-reset term |
| apreset_term | output | 1 | Shared asynchronous-preset term |

## Verification
Every output is a pure function of `in_vec` and the stored words, so a new input pattern is due at the outputs in the same cycle and a configuration write is due just after the rising edge that samples it. The bench drives inputs two nanoseconds after a rising edge, compares all outputs against a behavioural model of the store and terms at that point of every cycle, and probes directed cases one nanosecond after an input change. The timing checks look at a term once before and once after the write edge.

// File: rtl/pt_array_pkg.sv
package pt_array_pkg;
   // Control terms follow the general terms in the configuration address space.
   localparam int N_SPECIAL = 4;
   typedef enum int unsigned {
      SP_OE0    = 0,
      SP_OE1    = 1,
      SP_RESET  = 2,
      SP_PRESET = 3
   } spec_slot_e;

   // Address of a control term given the number of general terms.
   function automatic int spec_addr(int n_logic, spec_slot_e slot);
      return n_logic + int'(slot);
   endfunction
endpackage

// File: rtl/pt_cfg_store.sv
module pt_cfg_store #(
   parameter int N_WORDS = 69,
   parameter int W       = 44,
   parameter int ADDR_W  = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_ok,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [W-1:0]               data,
   output logic [N_WORDS-1:0][W-1:0]  words
);
   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '1;
         else if (wr_ok && addr == ADDR_W'(w))
            q <= data;
      end
      assign words[w] = q;
   end
endmodule

// File: rtl/pt_term.sv
module pt_term #(
   parameter int N_IN = 22
) (
   input  logic [N_IN-1:0]   sig,
   input  logic [2*N_IN-1:0] mask,
   output logic              term
);
   logic [2*N_IN-1:0] lit;

   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit[2*i]   = sig[i];
      assign lit[2*i+1] = ~sig[i];
   end

   // Unconnected literals are forced to 1 so they drop out of the AND.
   assign term = &(lit | ~mask);
endmodule

// File: rtl/pt_oe_select.sv
module pt_oe_select #(
   parameter int N_IO = 8
) (
   input  logic            oe_a,
   input  logic            oe_b,
   input  logic [N_IO-1:0] sel,
   output logic [N_IO-1:0] io_oe
);
   for (genvar i = 0; i < N_IO; i++) begin : g_cell
      assign io_oe[i] = sel[i] ? oe_b : oe_a;
   end
endmodule

// File: rtl/pt_array.sv
module pt_array
   import pt_array_pkg::*;
#(
   parameter int N_IN      = 22,
   parameter int N_LOGIC   = 64,
   parameter int CLUSTER_W = 4,
   parameter int N_IO      = 8,
   localparam int LIT_W    = 2 * N_IN,
   localparam int N_TERMS  = N_LOGIC + N_SPECIAL,
   localparam int SEL_ADDR = N_TERMS,
   localparam int N_WORDS  = N_TERMS + 1,
   localparam int ADDR_W   = $clog2(N_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_en,
   input  logic               cfg_wr,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [LIT_W-1:0]   cfg_data,
   input  logic [N_IN-1:0]    in_vec,
   output logic [N_LOGIC-1:0] logic_terms,
   output logic [N_IO-1:0]    io_oe,
   output logic               areset_term,
   output logic               apreset_term
);
   localparam int N_CLUSTERS = N_LOGIC / CLUSTER_W;
   localparam int A_OE0      = spec_addr(N_LOGIC, SP_OE0);
   localparam int A_OE1      = spec_addr(N_LOGIC, SP_OE1);
   localparam int A_RST      = spec_addr(N_LOGIC, SP_RESET);
   localparam int A_PRE      = spec_addr(N_LOGIC, SP_PRESET);

   if (N_IN < 1) begin : g_bad_in
      $error("pt_array: N_IN must be at least 1");
   end
   if (CLUSTER_W < 1 || N_LOGIC % CLUSTER_W != 0) begin : g_bad_cluster
      $error("pt_array: N_LOGIC must be a multiple of CLUSTER_W");
   end
   if (N_IO < 1 || N_IO > LIT_W) begin : g_bad_io
      $error("pt_array: select word must fit in one configuration word");
   end

   logic [N_WORDS-1:0][LIT_W-1:0] words;
   logic [N_TERMS-1:0]            term_vec;
   logic [N_IO-1:0]               oe_sel;
   logic                          sel_unused;

   pt_cfg_store #(
      .N_WORDS (N_WORDS),
      .W       (LIT_W),
      .ADDR_W  (ADDR_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_ok (cfg_en && cfg_wr),
      .addr  (cfg_addr),
      .data  (cfg_data),
      .words (words)
   );

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      pt_term #(.N_IN(N_IN)) u_term (
         .sig  (in_vec),
         .mask (words[t]),
         .term (term_vec[t])
      );
   end

   for (genvar c = 0; c < N_CLUSTERS; c++) begin : g_cluster
      assign logic_terms[c*CLUSTER_W +: CLUSTER_W] = term_vec[c*CLUSTER_W +: CLUSTER_W];
   end

   if (N_IO < LIT_W) begin : g_sel_narrow
      assign oe_sel     = words[SEL_ADDR][N_IO-1:0];
      assign sel_unused = ^words[SEL_ADDR][LIT_W-1:N_IO];
   end else begin : g_sel_full
      assign oe_sel     = words[SEL_ADDR];
      assign sel_unused = 1'b0;
   end

   pt_oe_select #(.N_IO(N_IO)) u_oe (
      .oe_a  (term_vec[A_OE0]),
      .oe_b  (term_vec[A_OE1]),
      .sel   (oe_sel),
      .io_oe (io_oe)
   );

   assign areset_term  = term_vec[A_RST];
   assign apreset_term = term_vec[A_PRE];
endmodule

// File: rtl/pt_array_chk.sv
module pt_array_chk #(
   parameter int N_IN    = 22,
   parameter int N_LOGIC = 64,
   parameter int N_IO    = 8,
   parameter int ADDR_W  = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_en,
   input logic               cfg_wr,
   input logic [ADDR_W-1:0]  cfg_addr,
   input logic [N_IN-1:0]    in_vec,
   input logic [N_LOGIC-1:0] logic_terms,
   input logic [N_IO-1:0]    io_oe,
   input logic               areset_term,
   input logic               apreset_term,
   input logic               oe_a,
   input logic               oe_b
);
   localparam int LAST_ADDR = N_LOGIC + 4;

   AST_ERASED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (logic_terms == '0 && io_oe == '0 && !areset_term && !apreset_term)); // R1

   AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_en && cfg_wr) && $stable(in_vec)) |->
      ($stable(logic_terms) && $stable(io_oe) && $stable(areset_term) && $stable(apreset_term))); // R8

   AST_HOLD_BAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_en && cfg_wr) && $past(cfg_addr) > ADDR_W'(LAST_ADDR) && $stable(in_vec)) |->
      ($stable(logic_terms) && $stable(io_oe) && $stable(areset_term) && $stable(apreset_term))); // R9

   AST_OE_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_a && !oe_b) |-> io_oe == '0); // R7

   AST_OE_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_a && oe_b) |-> io_oe == '1); // R7
endmodule

bind pt_array pt_array_chk #(
   .N_IN    (N_IN),
   .N_LOGIC (N_LOGIC),
   .N_IO    (N_IO),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_en       (cfg_en),
   .cfg_wr       (cfg_wr),
   .cfg_addr     (cfg_addr),
   .in_vec       (in_vec),
   .logic_terms  (logic_terms),
   .io_oe        (io_oe),
   .areset_term  (areset_term),
   .apreset_term (apreset_term),
   .oe_a         (term_vec[N_LOGIC]),
   .oe_b         (term_vec[N_LOGIC+1])
);

// File: tb/pt_array_test.sv
module pt_array_test;
   localparam int NI  = 22;
   localparam int NL  = 64;
   localparam int NIO = 8;
   localparam int SEL = NL + 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [6:0]    cfg_addr = '0;
   logic [43:0]   cfg_data = '0;
   logic [NI-1:0] in_vec = '0;
   logic [NL-1:0] logic_terms;
   logic [NIO-1:0] io_oe;
   logic          areset_term;
   logic          apreset_term;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   pt_array uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_en       (cfg_en),
      .cfg_wr       (cfg_wr),
      .cfg_addr     (cfg_addr),
      .cfg_data     (cfg_data),
      .in_vec       (in_vec),
      .logic_terms  (logic_terms),
      .io_oe        (io_oe),
      .areset_term  (areset_term),
      .apreset_term (apreset_term)
   );

   // Reference model of the configuration store.
   logic [43:0] mdl [SEL+1];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k <= SEL; k++) mdl[k] <= '1;
      end else if (cfg_en && cfg_wr && int'(cfg_addr) <= SEL) begin
         mdl[cfg_addr] <= cfg_data;
      end
   end

   function automatic bit m_term(int t);
      bit r = 1'b1;
      for (int i = 0; i < NI; i++) begin
         if (mdl[t][2*i]   && !in_vec[i]) r = 1'b0;
         if (mdl[t][2*i+1] &&  in_vec[i]) r = 1'b0;
      end
      return r;
   endfunction

   function automatic logic [NL-1:0] m_logic();
      logic [NL-1:0] v;
      for (int t = 0; t < NL; t++) v[t] = m_term(t);
      return v;
   endfunction

   function automatic logic [NIO-1:0] m_oe();
      logic [NIO-1:0] v;
      for (int i = 0; i < NIO; i++) v[i] = mdl[SEL][i] ? m_term(NL+1) : m_term(NL);
      return v;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      check("R2 general terms", logic_terms, m_logic());
      check("R7 io enables", 64'(io_oe), 64'(m_oe()));
      check("R5 reset/preset", 64'({areset_term, apreset_term}), 64'({m_term(NL+2), m_term(NL+3)}));
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      cmp_all();
   endtask

   task automatic wr(int addr, logic [43:0] data);
      cfg_en   = 1'b1;
      cfg_wr   = 1'b1;
      cfg_addr = 7'(addr);
      cfg_data = data;
      tick();
      cfg_en = 1'b0;
      cfg_wr = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [NL-1:0] snap;
      in_vec = 22'h2A5F3C;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: erased state, two input patterns
      check("R1 erased", {logic_terms[61:0], io_oe[0], areset_term}, 64'h0);
      in_vec = '1; #1;
      check("R1 erased", 64'({logic_terms[63:62], io_oe, apreset_term}), 64'h0);
      in_vec = '0; #1;
      check("R1 erased", logic_terms, 64'h0);

      // R2: term 0 = in0 & ~in1 (bit 0 true of input 0, bit 3 complement of input 1)
      wr(0, 44'h9);
      in_vec = 22'b01; #1;
      check("R2 and of literals", 64'(logic_terms[0]), 64'h1);
      in_vec = 22'b11; #1;
      check("R2 and of literals", 64'(logic_terms[0]), 64'h0);
      in_vec = 22'b00; #1;
      check("R2 and of literals", 64'(logic_terms[0]), 64'h0);
      // R10: input change seen without a clock edge
      in_vec = 22'b01; #1;
      check("R10 combinational input", 64'(logic_terms[0]), 64'h1);

      // R10: write takes effect at the sampling edge
      cfg_en = 1'b1; cfg_wr = 1'b1; cfg_addr = 7'd20; cfg_data = '0;
      #1;
      check("R10 before write edge", 64'(logic_terms[20]), 64'h0);
      @(posedge clk); #1;
      check("R10 after write edge", 64'(logic_terms[20]), 64'h1);
      cfg_en = 1'b0; cfg_wr = 1'b0;
      tick();

      // R3: empty term is 1
      wr(5, '0);
      in_vec = 22'h3FFFFF; #1;
      check("R3 empty term", 64'(logic_terms[5]), 64'h1);
      in_vec = 22'h155555; #1;
      check("R3 empty term", 64'(logic_terms[5]), 64'h1);

      // R6: cluster layout
      check("R6 cluster 1", 64'(logic_terms[7:4]), 64'h2);
      check("R6 cluster 5", 64'(logic_terms[23:20]), 64'h1);

      // R4: both polarities of input 3
      wr(9, 44'hC0);
      in_vec = '1; #1;
      check("R4 contradiction", 64'(logic_terms[9]), 64'h0);
      in_vec = '0; #1;
      check("R4 contradiction", 64'(logic_terms[9]), 64'h0);

      // R8: write refused without enable or strobe
      cfg_en = 1'b0; cfg_wr = 1'b1; cfg_addr = 7'd10; cfg_data = '0;
      tick();
      check("R8 enable low", 64'(logic_terms[10]), 64'h0);
      cfg_en = 1'b1; cfg_wr = 1'b0;
      tick();
      check("R8 strobe low", 64'(logic_terms[10]), 64'h0);
      cfg_en = 1'b0;

      // R9: address beyond the map
      snap = logic_terms;
      wr(100, '0);
      check("R9 bad address", logic_terms, snap);
      check("R9 bad address", 64'({io_oe, areset_term, apreset_term}), 64'h0);

      // R5: reset and preset terms
      wr(66, '0);
      check("R5 reset term", 64'({areset_term, apreset_term}), 64'h2);
      wr(67, '0);
      check("R5 preset term", 64'({areset_term, apreset_term}), 64'h3);

      // R7: output-enable selection (select word resets to ones -> term 1)
      wr(65, '0);
      check("R7 select term1", 64'(io_oe), 64'hFF);
      wr(68, 44'hA5);
      check("R7 mixed select", 64'(io_oe), 64'hA5);
      wr(64, '0);
      check("R7 both on", 64'(io_oe), 64'hFF);
      wr(65, '1);
      check("R7 term0 only", 64'(io_oe), 64'h5A);

      // Random phase against the model
      for (int n = 0; n < 600; n++) begin
         in_vec   = NI'($urandom);
         cfg_en   = ($urandom_range(0, 3) != 0);
         cfg_wr   = ($urandom_range(0, 1) != 0);
         cfg_addr = 7'($urandom_range(0, 75));
         cfg_data = {$urandom, $urandom} & {$urandom, $urandom} &
                    {$urandom, $urandom} & {$urandom, $urandom};
         tick();
      end
      cfg_en = 1'b0; cfg_wr = 1'b0;
      tick();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule